// File: doc/BRIEF.md
# Dual-Modulus Programmable Down-Counter Divider

This block divides its clock by a programmable ratio. An 8-bit down counter runs from a loaded value to zero. On the clock after it reaches zero it reloads from one of two stored division words. A select input picks the word at each reload, so the ratio can alternate from one output period to the next. This gives dual-modulus division, as used in fractional and pulse-swallow synthesizers.

Each division word sits in its own level-sensitive holding latch with its own load strobe. Software or a sequencer can rewrite a word while the counter runs, and the count in progress is not disturbed. A clock enable freezes the whole block. The output is a one-cycle terminal-count pulse, retimed through a flip-flop.

Top module: `div_dual_modulus`

## Requirements
- R1: A low `rstN` at a rising clock edge clears the counter to zero and `termCount` to 0. Because the counter is then zero, the first enabled clock after reset reloads it, and `termCount` is 1 in the cycle after that edge.
- R2: On an enabled clock edge with a nonzero count, the counter decrements by exactly one.
- R3: On an enabled clock edge with a zero count, the counter reloads from word A when `wordSel` is 0 and from word B when `wordSel` is 1. `wordSel` matters only at that edge.
- R4: `termCount` is registered. It is 1 for the cycle after each enabled edge at which the count was zero, and 0 after any other enabled edge. A stored word N therefore gives one high cycle every N+1 enabled clocks. A word of 0 keeps `termCount` at 1 continuously.
- R5: While `clkEn` is 0, both the counter and `termCount` keep their values.
- R6: Each word latch is transparent while its load strobe (`loadA` or `loadB`) is 1. It holds while the strobe is 0, whatever its data input does.
- R7: Writing either word while a count is in progress leaves that count unchanged. The new value first governs the period after the next reload.
- R8: Toggling `wordSel` once per period makes successive periods alternate between A+1 and B+1 clocks. Changing `wordSel` between reloads, and restoring it before the next reload, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Synchronous reset, active low |
| clkEn | input | 1 | Count enable; 0 freezes counter and output |
| wordSel | input | 1 | Reload word choice: 0 = word A, 1 = word B |
| loadA | input | 1 | Word A latch transparent while 1 |
| loadB | input | 1 | Word B latch transparent while 1 |
| wordA | input | 8 | Data for word A |
| wordB | input | 8 | Data for word B |
| termCount | output | 1 | Registered terminal-count pulse |

## Verification
The division ratio is swept for every word from 0 to 31 and for the top values 127, 128, 254 and 255. Each sweep runs once through word A and once through word B with the other word set far apart, so a wrong mux choice or an off-by-one ratio shows as a wrong period. Alternating `wordSel` once per period tells sampling at the reload edge apart from sampling at any other time. A select glitch that is restored before the reload must leave both periods unchanged. Mid-count rewrites, writes with the strobe held low, and enable gaps taken both with `termCount` high and with it low tell "takes effect at the next reload" and "hold" apart from immediate or lost updates.

// File: rtl/div_pkg.sv
package div_pkg;

  // Strobes from control to datapath for one clock edge
  typedef struct packed {
    logic clear;   // synchronous reset of counter and output
    logic reload;  // counter takes selected word
    logic step;    // counter decrements
    logic pulse;   // terminal-count register updates
  } divStrobeT;

endpackage

// File: rtl/div_word_bank.sv
module div_word_bank #(
  parameter int WIDTH     = 8,
  parameter int NUM_WORDS = 2
) (
  input  logic [NUM_WORDS-1:0]       load,
  input  logic [NUM_WORDS*WIDTH-1:0] din,
  output logic [NUM_WORDS*WIDTH-1:0] held
);

  for (genvar gi = 0; gi < NUM_WORDS; gi++) begin : g_word
    logic [WIDTH-1:0] heldWord;

    // Level-sensitive holding latch: open while its strobe is high
    always_latch begin
      if (load[gi]) heldWord <= din[gi*WIDTH +: WIDTH];
    end

    assign held[gi*WIDTH +: WIDTH] = heldWord;
  end

endmodule

// File: rtl/div_ctrl.sv
module div_ctrl
  import div_pkg::*;
(
  input  logic      rstN,
  input  logic      clkEn,
  input  logic      countZero,
  output divStrobeT strobe
);

  always_comb begin
    strobe        = '0;
    strobe.clear  = !rstN;
    if (rstN && clkEn) begin
      strobe.pulse  = 1'b1;
      strobe.reload = countZero;
      strobe.step   = !countZero;
    end
  end

endmodule

// File: rtl/div_datapath.sv
module div_datapath
  import div_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  divStrobeT        strobe,
  input  logic             wordSel,
  input  logic [WIDTH-1:0] heldA,
  input  logic [WIDTH-1:0] heldB,
  output logic [WIDTH-1:0] count,
  output logic             countZero,
  output logic             termCount
);

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] reloadWord;

  assign reloadWord = wordSel ? heldB : heldA;
  assign countZero  = (count == '0);

  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      count     <= '0;
      termCount <= 1'b0;
    end else begin
      if (strobe.reload)    count <= reloadWord;
      else if (strobe.step) count <= count - ONE;
      if (strobe.pulse)     termCount <= countZero;
    end
  end

endmodule

// File: rtl/div_dual_modulus.sv
module div_dual_modulus
  import div_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clkEn,
  input  logic             wordSel,
  input  logic             loadA,
  input  logic             loadB,
  input  logic [WIDTH-1:0] wordA,
  input  logic [WIDTH-1:0] wordB,
  output logic             termCount
);

  localparam int NUM_WORDS = 2;

  logic [NUM_WORDS*WIDTH-1:0] heldBus;
  logic [WIDTH-1:0]           heldA;
  logic [WIDTH-1:0]           heldB;
  logic [WIDTH-1:0]           count;
  logic                       countZero;
  divStrobeT                  strobe;

  div_word_bank #(.WIDTH(WIDTH), .NUM_WORDS(NUM_WORDS)) u_bank (
    .load ({loadB, loadA}),
    .din  ({wordB, wordA}),
    .held (heldBus)
  );

  assign heldA = heldBus[0 +: WIDTH];
  assign heldB = heldBus[WIDTH +: WIDTH];

  div_ctrl u_ctrl (
    .rstN      (rstN),
    .clkEn     (clkEn),
    .countZero (countZero),
    .strobe    (strobe)
  );

  div_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .strobe    (strobe),
    .wordSel   (wordSel),
    .heldA     (heldA),
    .heldB     (heldB),
    .count     (count),
    .countZero (countZero),
    .termCount (termCount)
  );

endmodule

// File: rtl/div_dual_modulus_chk.sv
module div_dual_modulus_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             clkEn,
  input logic             wordSel,
  input logic             loadA,
  input logic             loadB,
  input logic [WIDTH-1:0] wordA,
  input logic [WIDTH-1:0] wordB,
  input logic [WIDTH-1:0] heldA,
  input logic [WIDTH-1:0] heldB,
  input logic [WIDTH-1:0] count,
  input logic             termCount
);

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    !rstN |=> (count == '0 && !termCount));

  // R2
  step_down_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && count != '0) |=> count == $past(count) - WIDTH'(1));

  // R3
  reload_a_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && count == '0 && !wordSel) |=> count == $past(heldA));

  // R3
  reload_b_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && count == '0 && wordSel) |=> count == $past(heldB));

  // R4
  tc_follows_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    clkEn |=> termCount == $past(count == '0));

  // R5
  freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    !clkEn |=> ($stable(count) && $stable(termCount)));

  // R6
  latch_open_a_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadA |-> heldA == wordA);

  // R6
  latch_open_b_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadB |-> heldB == wordB);

  // R6
  latch_hold_a_chk: assert property (@(posedge clk) disable iff (!rstN)
    !loadA |=> (loadA || $stable(heldA)));

  // R6
  latch_hold_b_chk: assert property (@(posedge clk) disable iff (!rstN)
    !loadB |=> (loadB || $stable(heldB)));

endmodule

bind div_dual_modulus div_dual_modulus_chk #(.WIDTH(WIDTH)) chk (
  .clk       (clk),
  .rstN      (rstN),
  .clkEn     (clkEn),
  .wordSel   (wordSel),
  .loadA     (loadA),
  .loadB     (loadB),
  .wordA     (wordA),
  .wordB     (wordB),
  .heldA     (heldA),
  .heldB     (heldB),
  .count     (count),
  .termCount (termCount)
);

// File: tb/div_dual_modulus_test.sv
module div_dual_modulus_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       clkEn = 1'b1;
  logic       wordSel = 1'b0;
  logic       loadA = 1'b0;
  logic       loadB = 1'b0;
  logic [7:0] wordA = 8'd0;
  logic [7:0] wordB = 8'd0;
  logic       termCount;

  int total = 0;
  int bad = 0;
  bit doneFlag = 1'b0;

  always #5 clk = ~clk;

  div_dual_modulus #(.WIDTH(8)) uut (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .wordSel(wordSel),
    .loadA(loadA), .loadB(loadB), .wordA(wordA), .wordB(wordB),
    .termCount(termCount)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic setA(input int v);
    @(negedge clk); wordA = 8'(v); loadA = 1'b1;
    @(negedge clk); loadA = 1'b0;
  endtask

  task automatic setB(input int v);
    @(negedge clk); wordB = 8'(v); loadB = 1'b1;
    @(negedge clk); loadB = 1'b0;
  endtask

  // Count negedges until termCount is seen high
  task automatic nextTc(output int g);
    g = 0;
    do begin
      @(negedge clk);
      g++;
    end while (!termCount && g < 2000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    int g, g2, g3, d;

    // ---- R1: reset state and first reload ----
    wordA = 8'd4; loadA = 1'b1; wordB = 8'd200; loadB = 1'b1;
    repeat (3) @(negedge clk);
    loadA = 1'b0; loadB = 1'b0;
    check(termCount == 1'b0, "R1 reset output", termCount, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(termCount == 1'b1, "R1 first enabled clock reloads", termCount, 1);
    nextTc(g);
    check(g == 5, "R3 R4 period after reset word A=4", g, 5);

    // ---- R4/R3 sweep of both words ----
    for (int n = 0; n < 36; n++) begin
      int w;
      w = (n < 32) ? n : ((n == 32) ? 127 : (n == 33) ? 128 : (n == 34) ? 254 : 255);
      wordSel = 1'b0;
      setA(w); setB(255 - w);
      nextTc(d); nextTc(d); nextTc(g);
      check(g == w + 1, $sformatf("R4 R3 word A=%0d ratio", w), g, w + 1);
      wordSel = 1'b1;
      setB(w); setA(255 - w);
      nextTc(d); nextTc(d); nextTc(g);
      check(g == w + 1, $sformatf("R4 R3 word B=%0d ratio", w), g, w + 1);
    end

    // ---- R4: word zero keeps output high ----
    wordSel = 1'b0;
    setA(0);
    nextTc(d); nextTc(d);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(termCount == 1'b1, "R4 word zero stays high", termCount, 1);
    end

    // ---- R5: freeze while output high ----
    setA(9);
    nextTc(d); nextTc(d);
    clkEn = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(termCount == 1'b1, "R5 hold high while disabled", termCount, 1);
    end
    clkEn = 1'b1;
    nextTc(g);
    check(g == 10, "R5 count resumes after high hold", g, 10);

    // ---- R5: freeze while output low ----
    repeat (2) @(negedge clk);
    clkEn = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(termCount == 1'b0, "R5 hold low while disabled", termCount, 0);
    end
    clkEn = 1'b1;
    nextTc(g);
    check(g == 8, "R5 remaining count after low hold", g, 8);

    // ---- R6: closed latches ignore data ----
    setA(7);
    nextTc(d); nextTc(d);
    wordA = 8'd50;
    nextTc(g);
    check(g == 8, "R6 word A held with strobe low", g, 8);
    @(negedge clk); wordB = 8'd3; loadB = 1'b1;
    @(negedge clk); loadB = 1'b0;
    nextTc(d); nextTc(g);
    check(g == 8, "R6 loading word B leaves word A", g, 8);
    wordSel = 1'b1;
    nextTc(d); nextTc(g);
    check(g == 4, "R6 word B transparent load captured", g, 4);
    wordSel = 1'b0;

    // ---- R7: rewrite mid-count ----
    setA(20);
    nextTc(d); nextTc(d);
    repeat (3) @(negedge clk);
    wordA = 8'd5; loadA = 1'b1;
    @(negedge clk); loadA = 1'b0;
    wordB = 8'd1; loadB = 1'b1;
    @(negedge clk); loadB = 1'b0;
    nextTc(g2);
    check(5 + g2 == 21, "R7 count in progress undisturbed", 5 + g2, 21);
    nextTc(g3);
    check(g3 == 6, "R7 new word at next reload", g3, 6);

    // ---- R8: alternating select ----
    setA(3); setB(6);
    wordSel = 1'b0;
    nextTc(d); nextTc(d);
    for (int i = 0; i < 6; i++) begin
      int ex;
      ex = wordSel ? 7 : 4;
      wordSel = ~wordSel;
      nextTc(g);
      check(g == ex, "R8 alternating modulus", g, ex);
    end

    // ---- R8/R3: select glitch between reloads ----
    wordSel = 1'b0;
    setA(5); setB(9);
    nextTc(d); nextTc(d);
    repeat (2) @(negedge clk);
    wordSel = 1'b1;
    repeat (2) @(negedge clk);
    wordSel = 1'b0;
    nextTc(g);
    check(g + 4 == 6, "R8 glitch before reload ignored", g + 4, 6);
    nextTc(g);
    check(g == 6, "R3 select sampled only at reload", g, 6);

    // ---- R1: reset during count ----
    setA(30);
    nextTc(d); nextTc(d);
    repeat (4) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(termCount == 1'b0, "R1 mid-run reset clears output", termCount, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(termCount == 1'b1, "R1 reload right after reset", termCount, 1);
    nextTc(g);
    check(g == 31, "R1 R2 full period after reset", g, 31);

    finishRun();
  end

endmodule